// File: doc/BRIEF.md
# Seat Belt Reminder Alarm Controller

This block is a small synchronous controller that warns a driver who has started the vehicle with the seat belt still open. It watches three levels: the ignition key, the belt-fastened switch and a single-cycle time-base tick. When the key is switched on, the controller begins counting ticks. If the belt is still open after a short delay, it raises an alarm level. It drops the alarm when a longer timeout expires, when the belt is fastened, or when the key is switched off.

The control machine has three states: idle, waiting and alarming. An elapsed-tick counter provides both timeouts. Both thresholds are parameters, with defaults of 5 ticks for the alarm delay and 10 ticks for the cancel limit. Key-on is detected as a rising edge. After a timeout, the controller therefore stays quiet until the key has been switched off and on again. Input debouncing, tick generation and driving the buzzer or lamp belong to neighbouring blocks.

Top module: `seatbelt_alarm`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `state_code` reads 2'b00 and `alarm` is low. The stored previous key level is cleared to 0 by reset.
- R2: `state_code` encodes idle as 2'b00, waiting as 2'b01 and alarming as 2'b10. The value 2'b11 never appears at the output, and a register holding it goes to idle at the next edge.
- R3: In idle, a cycle where `key_on` is 1 and was 0 in the previous cycle moves the machine to waiting at the next edge, with the counter at zero.
- R4: After the machine returns to idle with `key_on` still held high, it stays in idle until `key_on` has been sampled 0 and then 1 again.
- R5: The counter advances by one only on cycles where `tick` is 1 while the machine is in waiting or alarming, and it holds at zero in idle. In waiting, the cycle after the counter reads DELAY is the first cycle in alarming.
- R6: In waiting, `key_on` low or `belt_ok` high returns the machine to idle at the next edge, and `alarm` stays low.
- R7: In alarming, the machine goes to idle and `alarm` falls at the next edge when the counter reads LIMIT, `belt_ok` is high, or `key_on` is low.
- R8: Key-off and belt-fastened win over a counter threshold reached in the same cycle. In waiting with the counter at DELAY, either of them sends the machine to idle, not to alarming.
- R9: `alarm` is a registered output. It is high in exactly those cycles where `state_code` reads 2'b10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_on | input | 1 | Ignition key level, 1 = on |
| belt_ok | input | 1 | Belt-fastened level, 1 = fastened |
| tick | input | 1 | Single-cycle time-base pulse |
| alarm | output | 1 | Registered alarm level |
| state_code | output | 2 | Current state: 00 idle, 01 waiting, 10 alarming |

## Verification
Directed sequences cover the following cases:
- A key-on with the belt open and ticks on every cycle, run to the cancel timeout. This separates the delay threshold from the limit threshold.
- The key held on after the timeout, then toggled off and on. This separates level detection from edge detection of the key.
- Belt-fastened and key-off events placed in waiting, in alarming, and on the exact cycle the counter reaches the delay. This separates priority from threshold order.
- Sparse and missing ticks. These show that only ticked cycles advance time.

A long stretch of seeded random key, belt and tick patterns is then compared cycle by cycle against a bench model built from the requirements.

// File: rtl/seatbelt_pkg.sv
package seatbelt_pkg;

  typedef enum logic [1:0] {
    SB_IDLE  = 2'b00,
    SB_WAIT  = 2'b01,
    SB_ALARM = 2'b10,
    SB_BAD   = 2'b11
  } sb_state_e;

endpackage

// File: rtl/sb_key_edge.sv
module sb_key_edge (
  input  logic clk,
  input  logic rst,
  input  logic key_on,
  output logic key_rise
);

  logic key_q;

  always_ff @(posedge clk) begin
    if (rst) key_q <= 1'b0;
    else     key_q <= key_on;
  end

  assign key_rise = key_on & ~key_q;

endmodule

// File: rtl/sb_tick_counter.sv
module sb_tick_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic          tick,
  output logic [CW-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst || clr)       count <= '0;
    else if (adv && tick) count <= count + 1'b1;
  end

endmodule

// File: rtl/sb_ctrl_fsm.sv
module sb_ctrl_fsm
  import seatbelt_pkg::*;
#(
  parameter int DELAY = 5,
  parameter int LIMIT = 10,
  parameter int CW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          key_rise,
  input  logic          key_on,
  input  logic          belt_ok,
  input  logic [CW-1:0] count,
  output sb_state_e     state,
  output logic          alarm,
  output logic          cnt_clr,
  output logic          cnt_adv
);

  localparam logic [CW-1:0] DLY_C = CW'(DELAY);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  sb_state_e nxt;
  logic      cancel;

  assign cancel = ~key_on | belt_ok;

  always_comb begin
    nxt = state;
    unique case (state)
      SB_IDLE:  if (key_rise) nxt = SB_WAIT;
      SB_WAIT: begin
        if (cancel)              nxt = SB_IDLE;
        else if (count == DLY_C) nxt = SB_ALARM;
      end
      SB_ALARM: if (cancel || count == LIM_C) nxt = SB_IDLE;
      default:  nxt = SB_IDLE;
    endcase
  end

  assign cnt_clr = (nxt == SB_IDLE) || (state != SB_WAIT && state != SB_ALARM);
  assign cnt_adv = ~cnt_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SB_IDLE;
      alarm <= 1'b0;
    end else begin
      state <= nxt;
      alarm <= (nxt == SB_ALARM);
    end
  end

endmodule

// File: rtl/seatbelt_alarm.sv
module seatbelt_alarm
  import seatbelt_pkg::*;
#(
  parameter int DELAY = 5,
  parameter int LIMIT = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_on,
  input  logic       belt_ok,
  input  logic       tick,
  output logic       alarm,
  output logic [1:0] state_code
);

  localparam int CW = $clog2(LIMIT + 1);

  logic          key_rise;
  logic          cnt_clr;
  logic          cnt_adv;
  logic [CW-1:0] cnt_w;
  sb_state_e     state_w;

  sb_key_edge edge_i (
    .clk      (clk),
    .rst      (rst),
    .key_on   (key_on),
    .key_rise (key_rise)
  );

  sb_tick_counter #(.CW(CW)) cnt_i (
    .clk   (clk),
    .rst   (rst),
    .clr   (cnt_clr),
    .adv   (cnt_adv),
    .tick  (tick),
    .count (cnt_w)
  );

  sb_ctrl_fsm #(.DELAY(DELAY), .LIMIT(LIMIT), .CW(CW)) fsm_i (
    .clk      (clk),
    .rst      (rst),
    .key_rise (key_rise),
    .key_on   (key_on),
    .belt_ok  (belt_ok),
    .count    (cnt_w),
    .state    (state_w),
    .alarm    (alarm),
    .cnt_clr  (cnt_clr),
    .cnt_adv  (cnt_adv)
  );

  assign state_code = state_w;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
  parameter int DELAY = 5,
  parameter int LIMIT = 10,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          key_on,
  input logic          belt_ok,
  input logic          alarm,
  input logic [1:0]    state_code,
  input logic [CW-1:0] count
);

  // R2
  no_bad_code_chk: assert property (@(posedge clk) disable iff (rst)
    state_code != 2'b11);

  // R9
  alarm_state_chk: assert property (@(posedge clk) disable iff (rst)
    alarm == (state_code == 2'b10));

  // R5
  idle_count_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b00) |-> (count == '0));

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(LIMIT));

  // R5
  alarm_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b01 && count == CW'(DELAY) && key_on && !belt_ok) |=> (state_code == 2'b10));

  // R6
  wait_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b01 && (!key_on || belt_ok)) |=> (state_code == 2'b00 && !alarm));

  // R7
  alarm_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b10 && (!key_on || belt_ok || count == CW'(LIMIT))) |=> (state_code == 2'b00));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_code == 2'b00 && !key_on) |=> (state_code == 2'b00));

endmodule

bind seatbelt_alarm sb_checker #(.DELAY(DELAY), .LIMIT(LIMIT), .CW(CW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .key_on     (key_on),
  .belt_ok    (belt_ok),
  .alarm      (alarm),
  .state_code (state_code),
  .count      (cnt_w)
);

// File: tb/seatbelt_alarm_tb_top.sv
module seatbelt_alarm_tb_top;

  localparam int DELAY = 5;
  localparam int LIMIT = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_on = 1'b0;
  logic       belt_ok = 1'b0;
  logic       tick = 1'b0;
  logic       alarm;
  logic [1:0] state_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int   m_state = 0;
  int   m_cnt = 0;
  logic m_keyq = 1'b0;

  always #2.5 clk = ~clk;

  seatbelt_alarm #(.DELAY(DELAY), .LIMIT(LIMIT)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .key_on     (key_on),
    .belt_ok    (belt_ok),
    .tick       (tick),
    .alarm      (alarm),
    .state_code (state_code)
  );

  function automatic int next_state(int s, int c, logic k, logic b, logic kq);
    logic cancel = !k || b;
    case (s)
      0: return (k && !kq) ? 1 : 0;
      1: return cancel ? 0 : (c == DELAY) ? 2 : 1;
      2: return (cancel || c == LIMIT) ? 0 : 2;
      default: return 0;
    endcase
  endfunction

  function automatic int next_cnt(int s, int ns, int c, logic t);
    if (s == 0 || ns == 0) return 0;
    return t ? c + 1 : c;
  endfunction

  task automatic check(string tag);
    checks++;
    if (state_code != 2'(m_state) || alarm != (m_state == 2)) begin
      errors++;
      $display("FAIL %s: state=%0d alarm=%0b expected state=%0d alarm=%0b",
               tag, state_code, alarm, m_state, (m_state == 2));
    end
  endtask

  task automatic step(logic k, logic b, logic t, string tag);
    int ns;
    @(negedge clk);
    key_on = k; belt_ok = b; tick = t;
    ns = next_state(m_state, m_cnt, k, b, m_keyq);
    m_cnt = next_cnt(m_state, ns, m_cnt, t);
    m_state = ns;
    m_keyq = k;
    @(posedge clk);
    #1;
    check(tag);
  endtask

  initial begin
    #(5 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EA7B317));
    repeat (3) @(posedge clk);
    #1;
    check("R1 during reset");
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R1 after reset");

    // R3 key rising edge, R5 delay with ticks every cycle, R7 limit timeout
    step(1, 0, 1, "R3 key on");
    for (int i = 0; i < LIMIT + 2; i++) step(1, 0, 1, "R5 R7 timeout run");
    // R4 key held on after timeout: no re-arm
    for (int i = 0; i < 6; i++) step(1, 0, 1, "R4 no rearm");
    step(0, 0, 1, "R4 key off");
    step(1, 0, 0, "R3 re-arm");
    // R5 no ticks: waiting holds
    for (int i = 0; i < 8; i++) step(1, 0, 0, "R5 no ticks");
    // R6 belt fastened in waiting
    step(1, 1, 1, "R6 belt in wait");
    step(0, 0, 0, "R6 key off");
    step(1, 0, 1, "R3 key on");
    step(0, 0, 1, "R6 key off in wait");
    // R8 threshold with belt in the same cycle
    step(1, 0, 0, "R3 key on");
    for (int i = 0; i < DELAY; i++) step(1, 0, 1, "R5 count up");
    step(1, 1, 0, "R8 belt wins at delay");
    step(0, 0, 0, "R8 key off");
    step(1, 0, 0, "R3 key on");
    for (int i = 0; i < DELAY; i++) step(1, 0, 1, "R5 count up");
    step(0, 0, 1, "R8 key off wins at delay");
    // R7 belt and key-off in alarming
    step(1, 0, 0, "R3 key on");
    for (int i = 0; i < DELAY + 2; i++) step(1, 0, 1, "R9 into alarm");
    step(1, 1, 0, "R7 belt in alarm");
    step(0, 0, 0, "R7 key off");
    step(1, 0, 0, "R3 key on");
    for (int i = 0; i < DELAY + 2; i++) step(1, 0, 1, "R9 into alarm");
    step(0, 0, 0, "R7 key off in alarm");

    // random stretch: key mostly on, belt mostly open, sparse ticks
    for (int i = 0; i < 4000; i++) begin
      logic k = ($urandom_range(0, 15) != 0);
      logic b = ($urandom_range(0, 19) == 0);
      logic t = ($urandom_range(0, 2) == 0);
      step(k, b, t, "R2 R5 R7 R9 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule